// File: doc/BRIEF.md
# Triple-Buffer Audio Block Ring

This block sits between an audio source that produces one sample at a time and an output path that wants whole blocks of samples on demand. It keeps three equal-length buffers inside a single memory. The source writes into the "fill" buffer one sample per accepted strobe. The output side reads the "drain" buffer as a contiguous stream whenever it raises a block request.

The two sides do not need to run at matched rates. When the source runs ahead, the fill side refuses to step onto the buffer the consumer owns. It rewrites its own buffer instead, so the newest audio is lost rather than the block being played. When the consumer runs ahead, the drain side moves on regardless and may land on the buffer still being filled. It then replays whatever that buffer holds and raises a one-cycle overlap flag, so the output never stalls.

Top module: `audio_tribuf`

## Requirements
- R1: While `rst` is high at a rising edge, the block resets to: `fill_idx` = 0, `drain_idx` = 1, write position 0, consumer idle, `blk_valid` = 0, `blk_last` = 0 and `blk_overlap` = 0.
- R2: Each cycle with `smp_valid` high stores `smp_data` at the current write position of the buffer named by `fill_idx`. The position then increments, and after position BLOCK_LEN-1 it wraps to 0. Buffer k occupies memory words k*BLOCK_LEN through k*BLOCK_LEN+BLOCK_LEN-1, and indices are binary 0, 1, 2.
- R3: On the edge that stores position BLOCK_LEN-1, the candidate index is (fill_idx+1) mod 3. `fill_idx` takes the candidate only if it differs from the `drain_idx` value held before that edge. Otherwise `fill_idx` is unchanged and the same buffer is refilled from position 0.
- R4: A `blk_req` sampled high at a rising edge while the consumer is idle starts a block. `blk_valid` is then high for exactly BLOCK_LEN consecutive cycles, beginning with the cycle after the next rising edge. `blk_data` carries positions 0 through BLOCK_LEN-1 of the drain buffer, in order.
- R5: `blk_req` has no effect while a block is being streamed.
- R6: `blk_last` is high only in the cycle that carries position BLOCK_LEN-1.
- R7: `drain_idx` becomes (drain_idx+1) mod 3 in the same cycle that `blk_last` is high, whatever the fill state.
- R8: If a block starts while `drain_idx` equals `fill_idx`, `blk_overlap` is high for exactly the one cycle after the start edge. The block streams the current contents of that buffer without waiting.
- R9: When a word is read for the stream and written by the source on the same edge, the stream carries the word's previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Source sample strobe |
| smp_data | input | SAMPLE_W | Source sample |
| blk_req | input | 1 | Consumer block-start request |
| blk_valid | output | 1 | Stream sample valid |
| blk_data | output | SAMPLE_W | Stream sample |
| blk_last | output | 1 | Final sample of a block |
| fill_idx | output | 2 | Buffer the source writes |
| drain_idx | output | 2 | Buffer the consumer reads next |
| blk_overlap | output | 1 | One-cycle pulse: block started on the fill buffer |

## Verification
The bench builds the block with BLOCK_LEN = 8 and 8-bit samples. With buffers that short, a few thousand cycles cover hundreds of wraps of both positions. This exercises every ordering of the three indices, including refused fill steps and drains onto the fill buffer. Three phases run: a fast source against a slow consumer, a slow source against back-to-back blocks, and near-equal rates. Only near-equal rates make same-word read and write collisions likely.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int NUM_BUFS = 3;

    typedef logic [1:0] buf_idx_t;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_t;

    // next buffer index around the ring of three
    function automatic buf_idx_t idx_next(input buf_idx_t i);
        return (i == buf_idx_t'(NUM_BUFS - 1)) ? buf_idx_t'(0) : i + buf_idx_t'(1);
    endfunction

endpackage

// File: rtl/tbr_store.sv
module tbr_store #(
    parameter int SAMPLE_W  = 8,
    parameter int BLOCK_LEN = 256,
    localparam int DEPTH    = tbr_pkg::NUM_BUFS * BLOCK_LEN,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [SAMPLE_W-1:0] rd_data
);

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // read returns the old word when the same word is written this edge (R9)
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= mem[rd_addr];
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

endmodule

// File: rtl/tbr_fill_ctrl.sv
module tbr_fill_ctrl
    import tbr_pkg::*;
#(
    parameter int BLOCK_LEN = 256,
    localparam int DEPTH    = NUM_BUFS * BLOCK_LEN,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = $clog2(BLOCK_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  buf_idx_t      drain_idx,
    output buf_idx_t      fill_idx,
    output logic [AW-1:0] wr_addr
);

    localparam logic [PW-1:0] POS_LAST = PW'(BLOCK_LEN - 1);

    logic [PW-1:0] wpos;
    buf_idx_t      cand;

    assign cand    = idx_next(fill_idx);
    assign wr_addr = AW'(int'(fill_idx) * BLOCK_LEN + int'(wpos));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_idx <= buf_idx_t'(0);
            wpos     <= '0;
        end else if (wr_valid) begin
            if (wpos == POS_LAST) begin
                wpos <= '0;
                if (cand != drain_idx)
                    fill_idx <= cand;
            end else begin
                wpos <= wpos + PW'(1);
            end
        end
    end

    // R3
    fill_avoids_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_idx != $past(fill_idx)) |->
            (fill_idx != $past(drain_idx) && fill_idx == idx_next($past(fill_idx))));

    // R3
    fill_moves_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_idx != $past(fill_idx)) |-> ($past(wr_valid) && wpos == '0));

    // R2
    wpos_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(wpos));

endmodule

// File: rtl/tbr_drain_ctrl.sv
module tbr_drain_ctrl
    import tbr_pkg::*;
#(
    parameter int BLOCK_LEN = 256,
    localparam int DEPTH    = NUM_BUFS * BLOCK_LEN,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = $clog2(BLOCK_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_req,
    input  buf_idx_t      fill_idx,
    output buf_idx_t      drain_idx,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid,
    output logic          out_last,
    output logic          overlap
);

    localparam logic [PW-1:0] POS_LAST = PW'(BLOCK_LEN - 1);

    rd_state_t     state;
    logic [PW-1:0] rpos;
    logic          at_end;

    assign rd_en   = (state == RD_STREAM);
    assign at_end  = rd_en && (rpos == POS_LAST);
    assign rd_addr = AW'(int'(drain_idx) * BLOCK_LEN + int'(rpos));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_IDLE;
            rpos      <= '0;
            drain_idx <= buf_idx_t'(1);
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            overlap   <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_last  <= at_end;
            overlap   <= (state == RD_IDLE) && blk_req && (drain_idx == fill_idx);
            case (state)
                RD_IDLE: begin
                    if (blk_req) begin
                        state <= RD_STREAM;
                        rpos  <= '0;
                    end
                end
                RD_STREAM: begin
                    if (rpos == POS_LAST) begin
                        state     <= RD_IDLE;
                        rpos      <= '0;
                        drain_idx <= idx_next(drain_idx);
                    end else begin
                        rpos <= rpos + PW'(1);
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // R7
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_idx != $past(drain_idx)) |->
            (out_last && drain_idx == idx_next($past(drain_idx))));

    // R8
    overlap_then_stream_chk: assert property (@(posedge clk) disable iff (rst)
        overlap |=> (out_valid && !overlap));

    // R6
    stream_ends_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_last));

    // R5
    stream_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

endmodule

// File: rtl/audio_tribuf.sv
module audio_tribuf
    import tbr_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int BLOCK_LEN = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                blk_req,
    output logic                blk_valid,
    output logic [SAMPLE_W-1:0] blk_data,
    output logic                blk_last,
    output logic [1:0]          fill_idx,
    output logic [1:0]          drain_idx,
    output logic                blk_overlap
);

    localparam int DEPTH = NUM_BUFS * BLOCK_LEN;
    localparam int AW    = $clog2(DEPTH);

    buf_idx_t      fill_w;
    buf_idx_t      drain_w;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          rd_en;

    tbr_fill_ctrl #(.BLOCK_LEN(BLOCK_LEN)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (smp_valid),
        .drain_idx (drain_w),
        .fill_idx  (fill_w),
        .wr_addr   (wr_addr)
    );

    tbr_drain_ctrl #(.BLOCK_LEN(BLOCK_LEN)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .blk_req   (blk_req),
        .fill_idx  (fill_w),
        .drain_idx (drain_w),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .out_valid (blk_valid),
        .out_last  (blk_last),
        .overlap   (blk_overlap)
    );

    tbr_store #(.SAMPLE_W(SAMPLE_W), .BLOCK_LEN(BLOCK_LEN)) u_store (
        .clk     (clk),
        .wr_en   (smp_valid),
        .wr_addr (wr_addr),
        .wr_data (smp_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (blk_data)
    );

    assign fill_idx  = fill_w;
    assign drain_idx = drain_w;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (fill_idx == 2'd0 && drain_idx == 2'd1 && !blk_valid && !blk_overlap));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_idx != 2'd3) && (drain_idx != 2'd3));

endmodule

// File: tb/audio_tribuf_tb.sv
module audio_tribuf_tb;

    localparam int W = 8;
    localparam int L = 8;
    localparam int N = 3 * L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         blk_req = 1'b0;
    logic         blk_valid;
    logic [W-1:0] blk_data;
    logic         blk_last;
    logic [1:0]   fill_idx;
    logic [1:0]   drain_idx;
    logic         blk_overlap;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    audio_tribuf #(.SAMPLE_W(W), .BLOCK_LEN(L)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .blk_req(blk_req), .blk_valid(blk_valid), .blk_data(blk_data),
        .blk_last(blk_last), .fill_idx(fill_idx), .drain_idx(drain_idx),
        .blk_overlap(blk_overlap)
    );

    // behavioural reference
    int m_fill, m_drain, m_wpos, m_rpos;
    bit m_busy, m_v, m_last, m_ov, m_data_ok;
    int m_data;
    int m_mem [N];
    bit m_written [N];
    int ov_seen = 0, blocked_seen = 0, ignored_seen = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_fill = 0; m_drain = 1; m_wpos = 0; m_rpos = 0;
            m_busy = 0; m_v = 0; m_last = 0; m_ov = 0; m_data_ok = 0;
        end else begin
            int nd;
            nd = m_drain;
            if (m_busy) begin
                int a;
                a = m_drain * L + m_rpos;
                m_data = m_mem[a];
                m_data_ok = m_written[a];
                m_v = 1;
                m_last = (m_rpos == L - 1);
            end else begin
                m_v = 0;
                m_last = 0;
            end
            m_ov = !m_busy && blk_req && (m_drain == m_fill);
            if (m_ov) ov_seen++;
            if (m_busy && blk_req) ignored_seen++;
            if (m_busy) begin
                if (m_rpos == L - 1) begin
                    m_busy = 0; m_rpos = 0; nd = (m_drain + 1) % 3;
                end else m_rpos++;
            end else if (blk_req) begin
                m_busy = 1; m_rpos = 0;
            end
            if (smp_valid) begin
                m_mem[m_fill * L + m_wpos] = int'(smp_data);
                m_written[m_fill * L + m_wpos] = 1;
                if (m_wpos == L - 1) begin
                    m_wpos = 0;
                    if ((m_fill + 1) % 3 != m_drain) m_fill = (m_fill + 1) % 3;
                    else blocked_seen++;
                end else m_wpos++;
            end
            m_drain = nd;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(int'(fill_idx) == m_fill, "R3 fill_idx", int'(fill_idx), m_fill);
        chk(int'(drain_idx) == m_drain, "R7 drain_idx", int'(drain_idx), m_drain);
        chk(blk_valid == m_v, "R4/R5 blk_valid", int'(blk_valid), int'(m_v));
        chk(blk_last == m_last, "R6 blk_last", int'(blk_last), int'(m_last));
        chk(blk_overlap == m_ov, "R8 blk_overlap", int'(blk_overlap), int'(m_ov));
        if (m_v && m_data_ok)
            chk(int'(blk_data) == m_data, "R2/R9 blk_data", int'(blk_data), m_data);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_written[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk(fill_idx == 2'd0, "R1 fill reset", int'(fill_idx), 0);
        chk(drain_idx == 2'd1, "R1 drain reset", int'(drain_idx), 1);
        chk(!blk_valid && !blk_last && !blk_overlap, "R1 outputs reset",
            int'({blk_valid, blk_last, blk_overlap}), 0);
        rst = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            compare_all();
            smp_data = W'(c) ^ 8'h5a;
            if (c < 900) begin
                // fast source, slow consumer; extra request mid-block (R5)
                smp_valid = 1'b1;
                blk_req   = (c % 40 == 0) || (c % 40 == 3);
            end else if (c < 2000) begin
                // slow source, back-to-back blocks (R8)
                smp_valid = (c % 5 == 0);
                blk_req   = 1'b1;
            end else begin
                // near-equal rates (R9)
                smp_valid = (c % 7 != 0);
                blk_req   = (c % 9 == 0);
            end
        end
        @(negedge clk);
        compare_all();
        chk(blocked_seen > 0, "R3 refused fill step occurred", blocked_seen, 1);
        chk(ov_seen > 0, "R8 overlap occurred", ov_seen, 1);
        chk(ignored_seen > 0, "R5 request during block occurred", ignored_seen, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule